// File: doc/BRIEF.md
# Legacy System Control Register File

This block is a byte-wide register file that sits on a 16-bit I/O port space of a single-processor board. A host issues single-byte reads and writes, each as a one-cycle strobe with an address and, for writes, a data byte. The block decodes a fixed set of ports and gives each one its own behaviour:

- a reset-and-byte-order port, whose written bits become a soft-reset level and a little-endian mode flag;
- read-only board-identification constants;
- a disk-activity light bit;
- two non-volatile memory lock strobes;
- a 4-bit system control field;
- an I/O map-type bit that feeds an external address translator;
- a small scratch area.

Outputs are levels held in registers, plus two single-cycle lock pulses that a neighbouring memory device counts. A write to a port with no write function raises a one-cycle error flag. A read of a port with no register returns all ones.

Read data is registered. It appears, together with a valid flag, in the cycle after the read strobe. A read and a write may fall in the same cycle. When they do, the read returns the value held before that write.

Top module: `sysctl_regfile`

## Requirements
- R1: After synchronous active-high reset, every output is 0. The control field, map bit and scratch bytes also read back as 0.
- R2: Port 0x092 behaves as follows.
  - A write sets soft_reset to data bit 0 and little_endian to data bit 1, visible in the cycle after the write strobe.
  - A read of 0x092 returns 0x00.
- R3: Reads of the identification ports return fixed bytes: 0x800 gives 0xEF, 0x802 gives 0xAD, 0x803 gives 0xE0, 0x80C gives 0x3C, 0x810 gives 0x39, 0x818 gives 0x00 and 0x823 gives 0x03.
- R4: A read of any port not named in R2, R3, R8, R9 or R10 returns 0xFF. This includes 0x808, 0x812 and 0x814.
- R5: Writes to 0x800, 0x802, 0x803 and 0x814 are accepted with no error. They change no output and no stored value.
- R6: A write to 0x808 sets disk_led to data bit 0. The other data bits are ignored.
- R7: A write to 0x810 gives a one-cycle pulse on nv_lock_a, and a write to 0x812 gives a one-cycle pulse on nv_lock_b. Each pulse appears in the cycle after the strobe, whatever the data.
- R8: A write to 0x81C stores data bits 3..0. A read of 0x81C returns them, with bits 7..4 equal to 0.
- R9: A write to 0x850 stores data bit 0 as io_map_sparse. A read of 0x850 returns that bit in bit 0, with bits 7..1 equal to 0.
- R10: Ports 0x398 and 0x399 are independent 8-bit registers. Each reads back the last byte written to it.
- R11: Read timing works as follows.
  - rdata and rvalid are registered. rvalid is high exactly in the cycle after a read strobe.
  - When a read and a write hit the same port in one cycle, the read returns the value from before the write.
- R12: wr_err is high for one cycle after a write to any port outside the writable set {0x092, 0x398, 0x399, 0x800, 0x802, 0x803, 0x808, 0x810, 0x812, 0x814, 0x81C, 0x850}. It is low after writes to that set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | One-cycle read strobe |
| wr_en | input | 1 | One-cycle write strobe |
| addr | input | 16 | Port address |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Registered read data |
| rvalid | output | 1 | rdata valid, one cycle after rd_en |
| wr_err | output | 1 | Write to an unsupported port |
| soft_reset | output | 1 | Soft-reset request level |
| little_endian | output | 1 | Little-endian mode flag |
| io_map_sparse | output | 1 | I/O map-type bit for the address translator |
| disk_led | output | 1 | Disk-activity light state |
| nv_lock_a | output | 1 | Lock-toggle pulse 1 |
| nv_lock_b | output | 1 | Lock-toggle pulse 2 |

## Verification
A read and a write can hit the same storage port in one cycle. The read path must then see the value from before the write, not the data being written. The bench provokes this by raising both strobes together on scratch port 0x398 and on the control port 0x81C. It judges the result in two steps: the read returns the value from before the write, and a plain read in the next access returns the new value. Beyond that, full sweeps of reads and writes over ports 0x000 to 0xFFF compare every read byte and every error flag against a model of the port map computed in the bench.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

   // Fixed port numbers of the register file
   localparam logic [15:0] PORT_RSTCTL = 16'h0092;
   localparam logic [15:0] PORT_ID_CPU = 16'h0800;
   localparam logic [15:0] PORT_ID_FEA = 16'h0802;
   localparam logic [15:0] PORT_ID_STA = 16'h0803;
   localparam logic [15:0] PORT_LED    = 16'h0808;
   localparam logic [15:0] PORT_ID_EQP = 16'h080C;
   localparam logic [15:0] PORT_LOCK_A = 16'h0810;
   localparam logic [15:0] PORT_LOCK_B = 16'h0812;
   localparam logic [15:0] PORT_INERT  = 16'h0814;
   localparam logic [15:0] PORT_ID_KEY = 16'h0818;
   localparam logic [15:0] PORT_CTL    = 16'h081C;
   localparam logic [15:0] PORT_ID_CCH = 16'h0823;
   localparam logic [15:0] PORT_MAP    = 16'h0850;

   // Write-side decode: one flag per write function
   typedef struct packed {
      logic rstctl;
      logic inert;
      logic led;
      logic lock_a;
      logic lock_b;
      logic ctl;
      logic map;
   } wsel_t;

   // Read-side source selection
   typedef enum logic [2:0] {
      RK_CONST = 3'd0,
      RK_CTL   = 3'd1,
      RK_MAP   = 3'd2,
      RK_SCR   = 3'd3,
      RK_NONE  = 3'd4
   } rkind_t;

endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
   import sysctl_pkg::*;
#(
   parameter int          ADDR_W   = 16,
   parameter int          SCR_N    = 2,
   parameter logic [15:0] SCR_BASE = 16'h0398,
   localparam int         IDX_W    = $clog2(SCR_N)
) (
   input  logic [ADDR_W-1:0] addr,
   output wsel_t             wsel,
   output logic [SCR_N-1:0]  scr_oh,
   output logic [IDX_W-1:0]  scr_idx,
   output rkind_t            rkind,
   output logic [7:0]        const_val
);

   // scratch port match, one comparator per byte
   for (genvar g = 0; g < SCR_N; g++) begin : g_scr
      assign scr_oh[g] = (addr == ADDR_W'(SCR_BASE + 16'(g)));
   end

   always_comb begin
      scr_idx = '0;
      for (int i = 0; i < SCR_N; i++) begin
         if (scr_oh[i]) scr_idx = IDX_W'(i);
      end
   end

   // write functions
   always_comb begin
      wsel        = '0;
      wsel.rstctl = (addr == ADDR_W'(PORT_RSTCTL));
      wsel.inert  = (addr == ADDR_W'(PORT_ID_CPU)) ||
                    (addr == ADDR_W'(PORT_ID_FEA)) ||
                    (addr == ADDR_W'(PORT_ID_STA)) ||
                    (addr == ADDR_W'(PORT_INERT));
      wsel.led    = (addr == ADDR_W'(PORT_LED));
      wsel.lock_a = (addr == ADDR_W'(PORT_LOCK_A));
      wsel.lock_b = (addr == ADDR_W'(PORT_LOCK_B));
      wsel.ctl    = (addr == ADDR_W'(PORT_CTL));
      wsel.map    = (addr == ADDR_W'(PORT_MAP));
   end

   // read sources
   always_comb begin
      rkind     = RK_NONE;
      const_val = 8'h00;
      if      (addr == ADDR_W'(PORT_RSTCTL)) begin rkind = RK_CONST; const_val = 8'h00; end
      else if (addr == ADDR_W'(PORT_ID_CPU)) begin rkind = RK_CONST; const_val = 8'hEF; end
      else if (addr == ADDR_W'(PORT_ID_FEA)) begin rkind = RK_CONST; const_val = 8'hAD; end
      else if (addr == ADDR_W'(PORT_ID_STA)) begin rkind = RK_CONST; const_val = 8'hE0; end
      else if (addr == ADDR_W'(PORT_ID_EQP)) begin rkind = RK_CONST; const_val = 8'h3C; end
      else if (addr == ADDR_W'(PORT_LOCK_A)) begin rkind = RK_CONST; const_val = 8'h39; end
      else if (addr == ADDR_W'(PORT_ID_KEY)) begin rkind = RK_CONST; const_val = 8'h00; end
      else if (addr == ADDR_W'(PORT_ID_CCH)) begin rkind = RK_CONST; const_val = 8'h03; end
      else if (addr == ADDR_W'(PORT_CTL))    rkind = RK_CTL;
      else if (addr == ADDR_W'(PORT_MAP))    rkind = RK_MAP;
      else if (|scr_oh)                      rkind = RK_SCR;
   end

endmodule

// File: rtl/sysctl_store.sv
module sysctl_store
   import sysctl_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int SCR_N  = 2,
   parameter int CTL_W  = 4
) (
   input  logic                         clk,
   input  logic                         rst,
   input  logic                         wr_en,
   input  logic [DATA_W-1:0]            wdata,
   input  wsel_t                        wsel,
   input  logic [SCR_N-1:0]             scr_oh,
   output logic                         soft_q,
   output logic                         le_q,
   output logic                         led_q,
   output logic                         map_q,
   output logic [CTL_W-1:0]             ctl_q,
   output logic [SCR_N-1:0][DATA_W-1:0] scr_q,
   output logic                         lock_a_q,
   output logic                         lock_b_q,
   output logic                         err_q
);

   logic known;
   assign known = (|wsel) || (|scr_oh);

   always_ff @(posedge clk) begin
      if (rst) begin
         soft_q   <= 1'b0;
         le_q     <= 1'b0;
         led_q    <= 1'b0;
         map_q    <= 1'b0;
         ctl_q    <= '0;
         lock_a_q <= 1'b0;
         lock_b_q <= 1'b0;
         err_q    <= 1'b0;
      end else begin
         lock_a_q <= wr_en && wsel.lock_a;
         lock_b_q <= wr_en && wsel.lock_b;
         err_q    <= wr_en && !known;
         if (wr_en && wsel.rstctl) begin
            soft_q <= wdata[0];
            le_q   <= wdata[1];
         end
         if (wr_en && wsel.led) led_q <= wdata[0];
         if (wr_en && wsel.ctl) ctl_q <= wdata[CTL_W-1:0];
         if (wr_en && wsel.map) map_q <= wdata[0];
      end
   end

   for (genvar g = 0; g < SCR_N; g++) begin : g_scr
      always_ff @(posedge clk) begin
         if (rst)                     scr_q[g] <= '0;
         else if (wr_en && scr_oh[g]) scr_q[g] <= wdata;
      end
   end

   // R2
   rstctl_follow_chk: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) && $past(wr_en && wsel.rstctl) |->
         (soft_q == $past(wdata[0])) && (le_q == $past(wdata[1])));

   // R9
   map_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) && !$past(wr_en && wsel.map) |-> $stable(map_q));

endmodule

// File: rtl/sysctl_rdmux.sv
module sysctl_rdmux
   import sysctl_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int SCR_N  = 2,
   parameter int CTL_W  = 4,
   localparam int IDX_W = $clog2(SCR_N)
) (
   input  logic                         clk,
   input  logic                         rst,
   input  logic                         rd_en,
   input  rkind_t                       rkind,
   input  logic [7:0]                   const_val,
   input  logic [CTL_W-1:0]             ctl,
   input  logic                         map,
   input  logic [SCR_N-1:0][DATA_W-1:0] scr,
   input  logic [IDX_W-1:0]             scr_idx,
   output logic [DATA_W-1:0]            rdata_q,
   output logic                         rvalid_q
);

   logic [DATA_W-1:0] rnext;

   always_comb begin
      case (rkind)
         RK_CONST: rnext = DATA_W'(const_val);
         RK_CTL:   rnext = DATA_W'(ctl);
         RK_MAP:   rnext = DATA_W'(map);
         RK_SCR:   rnext = scr[scr_idx];
         default:  rnext = '1;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         rdata_q  <= '0;
         rvalid_q <= 1'b0;
      end else begin
         rvalid_q <= rd_en;
         if (rd_en) rdata_q <= rnext;
      end
   end

   // R4
   unmapped_ones_chk: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) && $past(rd_en) && ($past(rkind) == RK_NONE) |-> (&rdata_q));

endmodule

// File: rtl/sysctl_regfile.sv
module sysctl_regfile
   import sysctl_pkg::*;
#(
   parameter int          ADDR_W   = 16,
   parameter int          DATA_W   = 8,
   parameter int          SCR_N    = 2,
   parameter int          CTL_W    = 4,
   parameter logic [15:0] SCR_BASE = 16'h0398
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              rd_en,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              rvalid,
   output logic              wr_err,
   output logic              soft_reset,
   output logic              little_endian,
   output logic              io_map_sparse,
   output logic              disk_led,
   output logic              nv_lock_a,
   output logic              nv_lock_b
);

   localparam int IDX_W = $clog2(SCR_N);

   initial begin
      assert (ADDR_W >= 12) else $error("ADDR_W must cover the port map");
      assert (DATA_W >= 8)  else $error("DATA_W must hold a byte");
      assert (SCR_N >= 2)   else $error("SCR_N must be at least 2");
      assert (CTL_W >= 1 && CTL_W <= DATA_W) else $error("CTL_W out of range");
   end

   wsel_t                        wsel;
   logic [SCR_N-1:0]             scr_oh;
   logic [IDX_W-1:0]             scr_idx;
   rkind_t                       rkind;
   logic [7:0]                   const_val;
   logic [CTL_W-1:0]             ctl;
   logic [SCR_N-1:0][DATA_W-1:0] scr;

   sysctl_decode #(
      .ADDR_W(ADDR_W), .SCR_N(SCR_N), .SCR_BASE(SCR_BASE)
   ) u_decode (
      .addr(addr), .wsel(wsel), .scr_oh(scr_oh), .scr_idx(scr_idx),
      .rkind(rkind), .const_val(const_val)
   );

   sysctl_store #(
      .DATA_W(DATA_W), .SCR_N(SCR_N), .CTL_W(CTL_W)
   ) u_store (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wdata(wdata), .wsel(wsel),
      .scr_oh(scr_oh), .soft_q(soft_reset), .le_q(little_endian),
      .led_q(disk_led), .map_q(io_map_sparse), .ctl_q(ctl), .scr_q(scr),
      .lock_a_q(nv_lock_a), .lock_b_q(nv_lock_b), .err_q(wr_err)
   );

   sysctl_rdmux #(
      .DATA_W(DATA_W), .SCR_N(SCR_N), .CTL_W(CTL_W)
   ) u_rdmux (
      .clk(clk), .rst(rst), .rd_en(rd_en), .rkind(rkind),
      .const_val(const_val), .ctl(ctl), .map(io_map_sparse), .scr(scr),
      .scr_idx(scr_idx), .rdata_q(rdata), .rvalid_q(rvalid)
   );

   // R7
   lock_a_src_chk: assert property (@(posedge clk) disable iff (rst)
      nv_lock_a |-> $past(wr_en) && ($past(addr) == ADDR_W'(PORT_LOCK_A)));

   // R7
   lock_excl_chk: assert property (@(posedge clk) disable iff (rst)
      !(nv_lock_a && nv_lock_b));

   // R12
   err_src_chk: assert property (@(posedge clk) disable iff (rst)
      wr_err |-> $past(wr_en));

   // R11
   rvalid_src_chk: assert property (@(posedge clk) disable iff (rst)
      rvalid |-> $past(rd_en));

   // R11
   rvalid_follow_chk: assert property (@(posedge clk) disable iff (rst)
      rd_en |=> rvalid);

   // R8
   ctl_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
      rvalid && ($past(addr) == ADDR_W'(PORT_CTL)) |-> (rdata[DATA_W-1:CTL_W] == '0));

endmodule

// File: tb/sysctl_regfile_tb.sv
module sysctl_regfile_tb;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        rd_en = 1'b0;
   logic        wr_en = 1'b0;
   logic [15:0] addr = '0;
   logic [7:0]  wdata = '0;
   logic [7:0]  rdata;
   logic        rvalid, wr_err, soft_reset, little_endian;
   logic        io_map_sparse, disk_led, nv_lock_a, nv_lock_b;

   int checks = 0;
   int fails  = 0;

   // bench model of stored state
   logic       m_soft = 0, m_le = 0, m_led = 0, m_map = 0;
   logic [3:0] m_ctl = 0;
   logic [7:0] m_s0 = 0, m_s1 = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sysctl_regfile u_dut (
      .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .rvalid(rvalid), .wr_err(wr_err),
      .soft_reset(soft_reset), .little_endian(little_endian),
      .io_map_sparse(io_map_sparse), .disk_led(disk_led),
      .nv_lock_a(nv_lock_a), .nv_lock_b(nv_lock_b)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_rd(input logic [15:0] a);
      case (a)
         16'h092: return 8'h00;
         16'h800: return 8'hEF;
         16'h802: return 8'hAD;
         16'h803: return 8'hE0;
         16'h80C: return 8'h3C;
         16'h810: return 8'h39;
         16'h818: return 8'h00;
         16'h823: return 8'h03;
         16'h81C: return {4'h0, m_ctl};
         16'h850: return {7'h0, m_map};
         16'h398: return m_s0;
         16'h399: return m_s1;
         default: return 8'hFF;
      endcase
   endfunction

   function automatic logic writable(input logic [15:0] a);
      case (a)
         16'h092, 16'h398, 16'h399, 16'h800, 16'h802, 16'h803,
         16'h808, 16'h810, 16'h812, 16'h814, 16'h81C, 16'h850: return 1'b1;
         default: return 1'b0;
      endcase
   endfunction

   task automatic upd(input logic [15:0] a, input logic [7:0] d);
      case (a)
         16'h092: begin m_soft = d[0]; m_le = d[1]; end
         16'h808: m_led = d[0];
         16'h81C: m_ctl = d[3:0];
         16'h850: m_map = d[0];
         16'h398: m_s0 = d;
         16'h399: m_s1 = d;
         default: ;
      endcase
   endtask

   task automatic chk_levels(input string req);
      chk({req, " soft_reset"}, soft_reset, m_soft);
      chk({req, " little_endian"}, little_endian, m_le);
      chk({req, " disk_led"}, disk_led, m_led);
      chk({req, " io_map_sparse"}, io_map_sparse, m_map);
   endtask

   task automatic wr(input logic [15:0] a, input logic [7:0] d, input string req);
      @(negedge clk);
      wr_en = 1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 0;
      chk({req, " R12 wr_err"}, wr_err, !writable(a));
      chk({req, " R7 lock_a"}, nv_lock_a, a == 16'h810);
      chk({req, " R7 lock_b"}, nv_lock_b, a == 16'h812);
      upd(a, d);
      chk_levels(req);
   endtask

   task automatic rd(input logic [15:0] a, input string req);
      @(negedge clk);
      rd_en = 1; addr = a;
      @(negedge clk);
      rd_en = 0;
      chk({req, " R11 rvalid"}, rvalid, 1'b1);
      chk({req, " rdata"}, rdata, exp_rd(a));
   endtask

   task automatic rdwr(input logic [15:0] a, input logic [7:0] d, input string req);
      logic [7:0] old;
      old = exp_rd(a);
      @(negedge clk);
      rd_en = 1; wr_en = 1; addr = a; wdata = d;
      @(negedge clk);
      rd_en = 0; wr_en = 0;
      chk({req, " rvalid"}, rvalid, 1'b1);
      chk({req, " old data"}, rdata, old);
      upd(a, d);
   endtask

   task automatic finish_run;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 0;
      // R1 reset state
      chk("R1 rdata", rdata, 8'h00);
      chk("R1 rvalid", rvalid, 1'b0);
      chk("R1 wr_err", wr_err, 1'b0);
      chk("R1 lock_a", nv_lock_a, 1'b0);
      chk("R1 lock_b", nv_lock_b, 1'b0);
      chk_levels("R1");
      rd(16'h81C, "R1 ctl");
      rd(16'h850, "R1 map");
      rd(16'h398, "R1 scr0");
      rd(16'h399, "R1 scr1");

      // R2 reset/byte-order port, all four bit pairs
      for (int v = 0; v < 4; v++) begin
         wr(16'h092, 8'(v) | 8'hF0, "R2");
         rd(16'h092, "R2 read zero");
      end

      // R6 light bit, only bit 0 counts
      wr(16'h808, 8'hFE, "R6");
      wr(16'h808, 8'h01, "R6");

      // R7 lock pulses, data ignored, one cycle wide
      wr(16'h810, 8'h00, "R7 a");
      @(negedge clk);
      chk("R7 lock_a width", nv_lock_a, 1'b0);
      wr(16'h812, 8'hFF, "R7 b");
      @(negedge clk);
      chk("R7 lock_b width", nv_lock_b, 1'b0);

      // R8 control field
      wr(16'h81C, 8'hA5, "R8");
      rd(16'h81C, "R8 readback");
      wr(16'h81C, 8'hFF, "R8");
      rd(16'h81C, "R8 readback");

      // R9 map bit
      wr(16'h850, 8'hFE, "R9");
      rd(16'h850, "R9 readback");
      wr(16'h850, 8'h03, "R9");
      rd(16'h850, "R9 readback");

      // R10 scratch independence
      wr(16'h398, 8'h5A, "R10");
      wr(16'h399, 8'hC3, "R10");
      rd(16'h398, "R10 s0");
      rd(16'h399, "R10 s1");
      wr(16'h398, 8'h17, "R10");
      rd(16'h399, "R10 s1 untouched");
      rd(16'h398, "R10 s0 new");

      // R5 inert writes leave everything as it was
      wr(16'h800, 8'hFF, "R5");
      wr(16'h802, 8'h00, "R5");
      wr(16'h803, 8'hFF, "R5");
      wr(16'h814, 8'hFF, "R5");
      rd(16'h800, "R5 id kept");
      rd(16'h81C, "R5 ctl kept");
      rd(16'h850, "R5 map kept");
      rd(16'h398, "R5 s0 kept");
      rd(16'h399, "R5 s1 kept");

      // R11 idle cycle: no rvalid
      @(negedge clk);
      chk("R11 idle rvalid", rvalid, 1'b0);

      // R11 same-cycle read and write
      rdwr(16'h398, 8'hE4, "R11 scr");
      rd(16'h398, "R11 scr new");
      rdwr(16'h81C, 8'h39, "R11 ctl");
      rd(16'h81C, "R11 ctl new");

      // R3/R4 read sweep over the port window
      for (int a = 0; a < 4096; a++) begin
         rd(16'(a), (exp_rd(16'(a)) == 8'hFF) ? "R4 sweep" : "R3 sweep");
      end

      // R12 write sweep, then confirm stored state
      for (int a = 0; a < 4096; a++) begin
         wr(16'(a), 8'(a) ^ 8'h3C, "R12 sweep");
      end
      rd(16'h81C, "R12 ctl after sweep");
      rd(16'h850, "R12 map after sweep");
      rd(16'h398, "R12 s0 after sweep");
      rd(16'h399, "R12 s1 after sweep");

      finish_run();
   end

endmodule